// File: doc/BRIEF.md
# External Interrupt Noise Filter

This block cleans up one asynchronous external interrupt pin before the interrupt controller sees it. The pin is first brought into the system clock domain by a chain of flops. A counter clocked by the system clock then rejects short glitches. The cleaned level goes to an edge detector, which turns the selected transition into a request pulse one clock wide.

Two conditions bypass the glitch filter, so that the synchronized level drives the edge detector directly:

- a static noise-rejection option that is switched off;
- a low-frequency crystal mode, where counting system clocks would only add delay.

Flag storage, masking and vectoring are left to the interrupt controller.

With default parameters, a change on the pin that the filter accepts produces its request 11 clocks after the pin changes. In bypass the delay is 4 clocks.

Top module: `extint_noise_filter`

## Requirements
- R1: With the filter active (`nr_enable`=1, `lowfreq_xtal`=0), a pin pulse lasting fewer than FILTER_LEN (default 8) clocks produces no request.
- R2: With the filter active, a new pin level held for FILTER_LEN consecutive clocks is accepted. The request rises SYNC_STAGES+FILTER_LEN+1 (default 11) clocks after the pin change.
- R3: If the pin returns to the accepted level before the count completes, the count restarts from zero. Two 5-clock highs separated by one low clock produce no request.
- R4: `edge_sel`=0 selects rising edges and `edge_sel`=1 selects falling edges. A transition of the filtered level in the other direction produces no request.
- R5: When `lowfreq_xtal`=1, filtering is bypassed. A single-clock pin pulse produces a request SYNC_STAGES+2 (default 4) clocks after the pin change.
- R6: When `nr_enable`=0, filtering is likewise bypassed. A 2-clock pulse produces a request SYNC_STAGES+2 clocks after the pin change.
- R7: `irq_pulse` is high for exactly one clock per accepted transition of the selected direction.
- R8: During and after reset, the internal levels take the inactive level for the selected edge (low for rising, high for falling). A pin held at that level raises no request.
- R9: Changing `edge_sel` while the filtered level is steady raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external interrupt pin |
| edge_sel | input | 1 | Trigger edge: 0 rising, 1 falling |
| nr_enable | input | 1 | Static option: 1 enables glitch rejection |
| lowfreq_xtal | input | 1 | 1 when the oscillator runs in low-frequency crystal mode (forces bypass) |
| irq_pulse | output | 1 | Registered one-clock interrupt request |

## Verification
The assertions assume `nr_enable` and `lowfreq_xtal` do not change while the counter is partway through a count. They also assume reset is held long enough for the synchronizer to load its reset level.

The stimulus therefore changes the mode inputs only after the pin has been idle long enough for the filter to settle. It changes `edge_sel` only while the filtered level is steady, and it drives the pin only on falling clock edges. Pulse lengths sit just below and at the acceptance threshold.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= rst_val;
        else     sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= {STAGES{rst_val}};
        else     sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/extint_glitch_filter.sv
module extint_glitch_filter #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic bypass,
  input  logic d,
  output logic lvl
);
  localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= rst_val;
      cnt_q <= '0;
    end else if (bypass) begin
      lvl_q <= d;
      cnt_q <= '0;
    end else if (d == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_MAX) begin
      lvl_q <= d;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl = lvl_q;

  // R1: the counter never runs past the acceptance threshold
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);

  // R2: in filtering mode a level change only follows a full count
  p_hold_len_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(bypass) && (lvl_q != $past(lvl_q)))
      |-> ($past(cnt_q) == CNT_MAX));
endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det
  import extint_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_val,
  input  edge_kind_t kind,
  input  logic       lvl,
  output logic       irq
);
  logic prev_q;
  logic irq_q;
  logic hit;

  always_comb begin
    if (kind == EDGE_FALL) hit = prev_q & ~lvl;
    else                   hit = ~prev_q & lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= rst_val;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      irq_q  <= hit;
    end
  end

  assign irq = irq_q;

  // R7: a request never lasts longer than one clock
  p_single_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
endmodule

// File: rtl/extint_noise_filter.sv
module extint_noise_filter
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  input  logic edge_sel,
  input  logic nr_enable,
  input  logic lowfreq_xtal,
  output logic irq_pulse
);
  edge_kind_t kind;
  logic       idle_lvl;
  logic       bypass;
  logic       pin_sync;
  logic       filt_lvl;

  assign kind     = edge_kind_t'(edge_sel);
  assign idle_lvl = (kind == EDGE_FALL);
  assign bypass   = ~nr_enable | lowfreq_xtal;

  extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rst_val (idle_lvl),
    .d       (pin_raw),
    .q       (pin_sync)
  );

  extint_glitch_filter #(.LEN(FILTER_LEN)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .rst_val (idle_lvl),
    .bypass  (bypass),
    .d       (pin_sync),
    .lvl     (filt_lvl)
  );

  extint_edge_det u_edge (
    .clk     (clk),
    .rst     (rst),
    .rst_val (idle_lvl),
    .kind    (kind),
    .lvl     (filt_lvl),
    .irq     (irq_pulse)
  );

  // R8: no request in the first clock after reset
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_pulse);

  // R4/R9: a request needs a real change of the filtered level
  p_needs_change_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 1) && $past(!rst, 2) && irq_pulse)
      |-> ($past(filt_lvl, 1) != $past(filt_lvl, 2)));
endmodule

// File: tb/extint_noise_filter_tb.sv
`timescale 1ns/1ps
module extint_noise_filter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_raw = 1'b0;
  logic edge_sel = 1'b0;
  logic nr_enable = 1'b1;
  logic lowfreq_xtal = 1'b0;
  logic irq_pulse;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int double_hi = 0;
  logic prev_irq = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  extint_noise_filter u_dut (
    .clk          (clk),
    .rst          (rst),
    .pin_raw      (pin_raw),
    .edge_sel     (edge_sel),
    .nr_enable    (nr_enable),
    .lowfreq_xtal (lowfreq_xtal),
    .irq_pulse    (irq_pulse)
  );

  always @(negedge clk) begin
    if (!rst && irq_pulse) pulses++;
    if (!rst && irq_pulse && prev_irq) double_hi++;
    prev_irq = irq_pulse;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic v, input int n);
    @(negedge clk);
    pin_raw = v;
    idle(n);
    pin_raw = ~v;
  endtask

  task automatic latency(input logic v, output int lat);
    lat = -1;
    @(negedge clk);
    pin_raw = v;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (irq_pulse && lat < 0) lat = i;
    end
  endtask

  task automatic t_reset();
    int lat;
    rst = 1'b1;
    pin_raw = 1'b0;
    edge_sel = 1'b0;
    idle(5);
    check(irq_pulse == 1'b0, "R8 irq low in reset", irq_pulse, 0);
    rst = 1'b0;
    pulses = 0;
    idle(20);
    check(pulses == 0, "R8 rising idle after reset", pulses, 0);
    rst = 1'b1;
    edge_sel = 1'b1;
    pin_raw = 1'b1;
    idle(5);
    rst = 1'b0;
    pulses = 0;
    idle(20);
    check(pulses == 0, "R8 falling idle after reset", pulses, 0);
    rst = 1'b1;
    edge_sel = 1'b0;
    pin_raw = 1'b0;
    idle(5);
    rst = 1'b0;
    idle(5);
    lat = 0;
  endtask

  task automatic t_short();
    pulses = 0;
    pulse(1'b1, 7);
    idle(25);
    check(pulses == 0, "R1 7-clock glitch", pulses, 0);
    pulse(1'b1, 1);
    idle(25);
    check(pulses == 0, "R1 1-clock glitch", pulses, 0);
  endtask

  task automatic t_accept();
    int lat;
    pulses = 0;
    double_hi = 0;
    latency(1'b1, lat);
    check(lat == 11, "R2 accept latency", lat, 11);
    check(pulses == 1, "R7 one pulse per edge", pulses, 1);
    check(double_hi == 0, "R7 pulse width", double_hi, 0);
    pulses = 0;
    @(negedge clk);
    pin_raw = 1'b0;
    idle(30);
    check(pulses == 0, "R4 falling ignored in rising mode", pulses, 0);
  endtask

  task automatic t_restart();
    pulses = 0;
    pulse(1'b1, 5);
    pulse(1'b1, 5);
    pin_raw = 1'b0;
    idle(25);
    check(pulses == 0, "R3 reversion restarts count", pulses, 0);
  endtask

  task automatic t_fall();
    int lat;
    pulses = 0;
    @(negedge clk);
    edge_sel = 1'b1;
    idle(20);
    check(pulses == 0, "R9 edge select change", pulses, 0);
    @(negedge clk);
    pin_raw = 1'b1;
    idle(25);
    check(pulses == 0, "R4 rising ignored in falling mode", pulses, 0);
    latency(1'b0, lat);
    check(lat == 11, "R4 falling edge latency", lat, 11);
    check(pulses == 1, "R4 falling edge count", pulses, 1);
    @(negedge clk);
    edge_sel = 1'b0;
    idle(10);
  endtask

  task automatic t_lowfreq();
    int lat;
    pulses = 0;
    lowfreq_xtal = 1'b1;
    idle(10);
    @(negedge clk);
    pin_raw = 1'b1;
    @(negedge clk);
    pin_raw = 1'b0;
    lat = -1;
    for (int i = 2; i <= 20; i++) begin
      @(negedge clk);
      if (irq_pulse && lat < 0) lat = i;
    end
    check(lat == 4, "R5 bypass latency low-freq", lat, 4);
    check(pulses == 1, "R5 1-clock pulse passes", pulses, 1);
    lowfreq_xtal = 1'b0;
    idle(10);
  endtask

  task automatic t_nr_off();
    int lat;
    pulses = 0;
    nr_enable = 1'b0;
    idle(10);
    @(negedge clk);
    pin_raw = 1'b1;
    @(negedge clk);
    lat = (irq_pulse) ? 1 : -1;
    @(negedge clk);
    pin_raw = 1'b0;
    if (irq_pulse && lat < 0) lat = 2;
    for (int i = 3; i <= 20; i++) begin
      @(negedge clk);
      if (irq_pulse && lat < 0) lat = i;
    end
    check(lat == 4, "R6 bypass latency option off", lat, 4);
    check(pulses == 1, "R6 2-clock pulse passes", pulses, 1);
    nr_enable = 1'b1;
    idle(10);
    pulses = 0;
    pulse(1'b1, 3);
    idle(25);
    check(pulses == 0, "R1 filter restored", pulses, 0);
  endtask

  initial begin
    t_reset();
    t_short();
    t_accept();
    t_restart();
    t_fall();
    t_lowfreq();
    t_nr_off();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule